// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic read and write an asynchronous static RAM. The RAM has two chip selects of opposite polarity: one is active low and one is active high. It also has an active-low output enable and an active-low write enable. The user side is a single-command interface. A command carries an address, write data and a direction flag, and it is accepted on a valid/ready handshake. Read data comes back with a one-cycle valid pulse. On the memory side the controller drives the address, the four control lines, and the data-out value with its output-enable. The tri-state pad sits outside the block.

Each access runs through the same phases: optional turnaround, address setup, strobe, hold, and then back to idle. Two run-time wait counts set the length of the setup and strobe phases. Every write ends when the active strobes stop overlapping. Run-time style bits choose which control line is pulsed to make that overlap. The other lines are held asserted for the whole access. A standby input stops new commands from being taken, so the chip stays deselected for as long as standby is held.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset and in every idle cycle the memory pins are parked: `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. `rd_valid` is 0 and `req_ready` is 1 unless standby is requested.
- R2: A command is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only in the idle phase, so it is low from the cycle after acceptance until the access finishes.
- R3: During a read strobe, `mem_cs1_n`=0, `mem_cs2`=1, `mem_oe_n`=0 and `mem_we_n`=1. Read data is sampled on the last strobe cycle. It is presented on `rd_data` with `rd_valid` high for exactly one cycle, in cycle `setup_wait`+`strobe_wait`+3 counted from acceptance.
- R4: The address is driven `setup_wait`+1 cycles before the strobe overlap begins, and it stays stable through the overlap. The overlap lasts `strobe_wait`+1 cycles for both reads and writes.
- R5: After the strobe, one hold cycle follows. In it the address is unchanged and, for a write, the data stays driven and stable while the pulsed line is released.
- R6: Write style 0 (`wr_mode`=0) holds `mem_cs2`=1 and `mem_we_n`=0 through setup and hold, and pulses `mem_cs1_n` low.
- R7: Write style 1 (`wr_mode`=1) holds `mem_cs1_n`=0 and `mem_we_n`=0, and pulses `mem_cs2` high.
- R8: Write style 2 (`wr_mode`=2) holds `mem_cs1_n`=0 and `mem_cs2`=1, and pulses `mem_we_n` low.
- R9: Write style 3 (`wr_mode`=3) keeps all three lines inactive during setup and hold, and asserts `mem_cs1_n`=0, `mem_cs2`=1 and `mem_we_n`=0 together for the strobe.
- R10: `mem_dq_oe` is high only during a write access, and only while `mem_oe_n` is high in both the current and the previous cycle. It is never high during a read.
- R11: A write accepted right after a read is preceded by one turnaround cycle with the pins parked and `mem_dq_oe`=0. A write that follows a write has no such cycle.
- R12: While `standby_req` is high, `req_ready` is low, `req_valid` has no effect and the chip stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Controller idle and able to take a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| wr_mode | input | 2 | Write strobe style 0..3, taken at acceptance |
| setup_wait | input | CW | Extra setup cycles (setup lasts value+1) |
| strobe_wait | input | CW | Extra strobe cycles (strobe lasts value+1) |
| standby_req | input | 1 | Hold the chip deselected and refuse commands |
| rd_valid | output | 1 | One-cycle read-data valid pulse |
| rd_data | output | DW | Read data |
| mem_addr | output | AW | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DW | Data to the pad |
| mem_dq_oe | output | 1 | Pad output enable |
| mem_dq_in | input | DW | Data from the pad |

## Verification
The checker enforces the following on every cycle:
- the read control pattern whenever the output enable is low;
- the parked pins whenever the controller is ready;
- the refusal of commands under standby;
- address stability while a strobe overlap is active;
- write-data stability and the hold cycle at the end of each write;
- bus driving only while the memory's output has been disabled for two cycles;
- single-cycle read-valid pulses.

Other properties can only be shown by the bench's scenarios, because they need knowledge of what was requested:
- the exact cycle counts for each wait setting;
- the held and pulsed lines of each write style;
- that data written in each style reads back correctly;
- that a turnaround cycle appears only for a write after a read.

// File: rtl/sramc_pkg.sv
// Shared types for the SRAM access controller.
// Assumes: a single controller owns the memory pins.
package sramc_pkg;

    // Access phase of the sequencer
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TURN   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_t;

    // Write strobe style: which control line forms the pulse
    typedef enum logic [1:0] {
        WR_PULSE_CS1 = 2'd0,
        WR_PULSE_CS2 = 2'd1,
        WR_PULSE_WE  = 2'd2,
        WR_PULSE_ALL = 2'd3
    } wr_style_t;

    // Memory-side pin set
    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic oe_n;
        logic we_n;
        logic drive;
    } pins_t;

    localparam pins_t PINS_PARKED = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1,
                                      we_n: 1'b1, drive: 1'b0};

endpackage

// File: rtl/sramc_wait_timer.sv
// Down-counter for wait states. Loading N makes 'expired' high
// N cycles later; the counter then rests at zero.
// Assumes: load is pulsed on phase entry only.
module sramc_wait_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Count down towards zero after each load
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_sequencer.sv
// Phase sequencer: takes a command when idle, then steps through
// turnaround (write after read only), setup, strobe and hold.
// Assumes: the wait counts are stable while an access runs.
module sramc_sequencer
    import sramc_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          standby_req,
    input  logic [CW-1:0] setup_wait,
    input  logic [CW-1:0] strobe_wait,
    output phase_t        phase,
    output logic          op_write,
    output logic          req_ready,
    output logic          accept,
    output logic          sample_now
);

    phase_t        phase_q, phase_d;
    logic          write_q;
    logic          prev_read_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;

    sramc_wait_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // R2 R12: handshake only in idle and never under standby
    assign req_ready = (phase_q == PH_IDLE) && !standby_req;
    assign accept    = req_valid && req_ready;

    // Next phase and timer load decisions
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = setup_wait;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    if (req_write && prev_read_q) begin
                        phase_d = PH_TURN;           // R11
                    end else begin
                        phase_d  = PH_SETUP;
                        tmr_load = 1'b1;
                    end
                end
            end
            PH_TURN: begin
                phase_d  = PH_SETUP;
                tmr_load = 1'b1;
            end
            PH_SETUP: begin
                if (tmr_expired) begin
                    phase_d  = PH_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = strobe_wait;
                end
            end
            PH_STROBE: begin
                if (tmr_expired)
                    phase_d = PH_HOLD;
            end
            PH_HOLD:  phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase register and per-command direction history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            write_q     <= 1'b0;
            prev_read_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                write_q     <= req_write;
                prev_read_q <= !req_write;
            end
        end
    end

    assign phase      = phase_q;
    assign op_write   = write_q;
    // R3: sample on the last strobe cycle of a read
    assign sample_now = (phase_q == PH_STROBE) && tmr_expired && !write_q;

endmodule

// File: rtl/sramc_pin_map.sv
// Decodes phase, direction and write style into the memory pin set.
// Assumes: phase comes from a register, so outputs change only after edges.
module sramc_pin_map
    import sramc_pkg::*;
(
    input  phase_t    phase,
    input  logic      is_write,
    input  wr_style_t style,
    output pins_t     pins
);

    // Pin pattern for each phase
    always_comb begin
        pins = PINS_PARKED;
        unique case (phase)
            PH_SETUP, PH_HOLD: begin
                if (is_write) begin
                    pins.drive = 1'b1;
                    unique case (style)
                        WR_PULSE_CS1: begin pins.cs2 = 1'b1;   pins.we_n = 1'b0; end // R6
                        WR_PULSE_CS2: begin pins.cs1_n = 1'b0; pins.we_n = 1'b0; end // R7
                        WR_PULSE_WE:  begin pins.cs1_n = 1'b0; pins.cs2 = 1'b1;  end // R8
                        default:      ;                                              // R9
                    endcase
                end
            end
            PH_STROBE: begin
                pins.cs1_n = 1'b0;
                pins.cs2   = 1'b1;
                if (is_write) begin
                    pins.we_n  = 1'b0;
                    pins.drive = 1'b1;
                end else begin
                    pins.oe_n  = 1'b0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sramc_ctrl.sv
// Top of the SRAM access controller: captures a command, runs the
// sequencer and drives the memory pins and read-data return.
// Assumes: an external pad combines mem_dq_out/mem_dq_oe into a tri-state bus.
module sramc_ctrl
    import sramc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    wr_mode,
    input  logic [CW-1:0] setup_wait,
    input  logic [CW-1:0] strobe_wait,
    input  logic          standby_req,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs1_n,
    output logic          mem_cs2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    phase_t        phase;
    logic          op_write;
    logic          accept;
    logic          sample_now;
    pins_t         pins;
    wr_style_t     style_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rd_data_q;
    logic          rd_valid_q;

    sramc_sequencer #(.CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .standby_req (standby_req),
        .setup_wait  (setup_wait),
        .strobe_wait (strobe_wait),
        .phase       (phase),
        .op_write    (op_write),
        .req_ready   (req_ready),
        .accept      (accept),
        .sample_now  (sample_now)
    );

    sramc_pin_map u_map (
        .phase    (phase),
        .is_write (op_write),
        .style    (style_q),
        .pins     (pins)
    );

    // Capture the command; the address then stays put until the next one (R4 R5)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            style_q <= WR_PULSE_CS1;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            style_q <= wr_style_t'(wr_mode);
        end
    end

    // Read return: sample on the last strobe cycle, pulse valid once (R3)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= sample_now;
            if (sample_now)
                rd_data_q <= mem_dq_in;
        end
    end

    assign rd_valid   = rd_valid_q;
    assign rd_data    = rd_data_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_cs1_n  = pins.cs1_n;
    assign mem_cs2    = pins.cs2;
    assign mem_oe_n   = pins.oe_n;
    assign mem_we_n   = pins.we_n;
    assign mem_dq_oe  = pins.drive;

endmodule

// Protocol checker attached to every controller instance.
module sramc_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          standby_req,
    input logic          rd_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs1_n,
    input logic          mem_cs2,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);

    logic wr_ov;
    logic any_ov;
    assign wr_ov  = !mem_cs1_n && mem_cs2 && !mem_we_n;
    assign any_ov = !mem_cs1_n && mem_cs2 && (!mem_we_n || !mem_oe_n);

    // R10
    bus_drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

    // R3
    read_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs1_n && mem_cs2 && mem_we_n));

    // R1
    ready_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R12
    standby_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_req |-> !req_ready);

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_ov |-> $stable(mem_addr));

    // R5
    write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ov |-> (mem_dq_oe && $stable(mem_dq_out)));

    // R5
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_ov) |-> ($stable(mem_addr) && mem_dq_oe && $stable(mem_dq_out)));

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

bind sramc_ctrl sramc_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sramc_ctrl_test.sv
// Directed bench: a behavioural SRAM model and one task per scenario.
module sramc_ctrl_test;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    wr_mode = 2'd0;
    logic [CW-1:0] setup_wait = '0;
    logic [CW-1:0] strobe_wait = '0;
    logic          standby_req = 1'b0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int fails  = 0;
    int model_errs = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sramc_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (.*);

    // Behavioural memory
    logic [DW-1:0] mem [256];
    logic          prev_wr = 1'b0;
    logic [7:0]    prev_a  = '0;
    logic [DW-1:0] prev_d  = '0;

    function automatic logic [DW-1:0] init_val(int i);
        return 16'hA5C3 ^ DW'(i * 257);
    endfunction

    initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);

    wire rd_en = !mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n;
    wire wr_en = !mem_cs1_n && mem_cs2 && !mem_we_n;
    assign mem_dq_in = rd_en ? mem[mem_addr[7:0]] : '0;

    // Write commits when the overlap ends; watch for contention and data changes
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) model_errs++;
            if (wr_en && !mem_dq_oe) model_errs++;
            if (wr_en && prev_wr && (mem_dq_out != prev_d || mem_addr[7:0] != prev_a)) model_errs++;
            if (prev_wr && !wr_en) mem[prev_a] = prev_d;
            prev_wr = wr_en;
            prev_a  = mem_addr[7:0];
            prev_d  = mem_dq_out;
        end
    end

    task automatic chk(string rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [2:0] setup_pat(int m);
        case (m)
            0: return 3'b110;   // {cs1_n, cs2, we_n}
            1: return 3'b000;
            2: return 3'b011;
            default: return 3'b101;
        endcase
    endfunction

    task automatic do_write(int addr, int data, int m, int s, int a, bit exp_turn, string rq);
        int n = 1, first_drive = 0, ov_start = 0, ov_len = 0;
        bit hold_seen = 0, hold_drive = 0, turn_park = 1;
        logic [2:0] spat = '0, hpat = '0;
        int haddr = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(addr); req_wdata = DW'(data);
        wr_mode = 2'(m); setup_wait = CW'(s); strobe_wait = CW'(a);
        chk("R2", "ready before write", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "ready low while busy", int'(req_ready), 0);
        while (!req_ready && n < 200) begin
            if (mem_dq_oe && first_drive == 0) begin
                first_drive = n;
                spat = {mem_cs1_n, mem_cs2, mem_we_n};
            end
            if (first_drive == 0 && !(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n)) turn_park = 0;
            if (wr_en) begin
                if (ov_start == 0) ov_start = n;
                ov_len++;
            end else if (ov_start != 0 && !hold_seen) begin
                hold_seen = 1; hpat = {mem_cs1_n, mem_cs2, mem_we_n};
                hold_drive = mem_dq_oe; haddr = int'(mem_addr);
            end
            @(negedge clk); n++;
        end
        chk("R11", "first bus-drive cycle", first_drive, exp_turn ? 2 : 1);
        chk("R11", "parked before drive", int'(turn_park), 1);
        chk(rq, "setup pins", int'(spat), int'(setup_pat(m)));
        chk("R4", "overlap start", ov_start, first_drive + s + 1);
        chk("R4", "overlap length", ov_len, a + 1);
        chk("R5", "hold pins", int'(hpat), int'(setup_pat(m)));
        chk("R5", "hold drive", int'(hold_drive), 1);
        chk("R5", "hold address", haddr, addr);
        chk("R1", "cycles to idle", n, (exp_turn ? 1 : 0) + s + a + 4);
    endtask

    task automatic do_read(int addr, int s, int a, int exp, string rq);
        int n = 1, oe_start = 0, oe_len = 0, rdv_idx = 0, rdv_cnt = 0, bad = 0, drv = 0;
        int got = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(addr);
        setup_wait = CW'(s); strobe_wait = CW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        while ((!req_ready || n == 1) && n < 200) begin
            if (!mem_oe_n) begin
                if (oe_start == 0) oe_start = n;
                oe_len++;
                if (!(!mem_cs1_n && mem_cs2 && mem_we_n)) bad++;
            end
            if (mem_dq_oe) drv++;
            if (rd_valid) begin
                rdv_cnt++;
                if (rdv_idx == 0) begin rdv_idx = n; got = int'(rd_data); end
            end
            @(negedge clk); n++;
        end
        if (rd_valid) rdv_cnt++;
        chk("R3", "rd_valid cycle", rdv_idx, s + a + 3);
        chk("R3", "rd_valid pulses", rdv_cnt, 1);
        chk(rq, "read data", got, exp);
        chk("R3", "read pin pattern", bad, 0);
        chk("R4", "oe start", oe_start, s + 2);
        chk("R4", "oe length", oe_len, a + 1);
        chk("R10", "drive during read", drv, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "parked pins", int'({mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe}), 5'b10110);
        chk("R1", "ready after reset", int'(req_ready), 1);
        chk("R1", "rd_valid after reset", int'(rd_valid), 0);
    endtask

    task automatic t_write_styles();
        do_write(16'h0010, 16'h1234, 0, 1, 0, 1'b0, "R6");
        do_write(16'h0011, 16'hBEEF, 1, 0, 2, 1'b0, "R7");
        do_write(16'h0012, 16'h0F0F, 2, 2, 1, 1'b0, "R8");
        do_write(16'h0013, 16'hC001, 3, 3, 3, 1'b0, "R9");
        do_read(16'h0010, 0, 0, 16'h1234, "R6");
        do_read(16'h0011, 1, 1, 16'hBEEF, "R7");
        do_read(16'h0012, 0, 2, 16'h0F0F, "R8");
        do_read(16'h0013, 2, 0, 16'hC001, "R9");
    endtask

    task automatic t_read_timing();
        do_read(16'h0040, 0, 0, int'(init_val(16'h40)), "R3");
        do_read(16'h0041, 3, 2, int'(init_val(16'h41)), "R3");
        do_read(16'h00FE, 7, 5, int'(init_val(16'hFE)), "R3");
    endtask

    task automatic t_turnaround();
        do_read(16'h0050, 0, 0, int'(init_val(16'h50)), "R3");
        do_write(16'h0051, 16'h5A5A, 2, 0, 0, 1'b1, "R8");
        do_write(16'h0052, 16'hA5A5, 0, 0, 0, 1'b0, "R6");
        do_read(16'h0051, 0, 0, 16'h5A5A, "R11");
    endtask

    task automatic t_standby();
        int sel = 0, rdy = 0;
        @(negedge clk);
        standby_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0077; req_wdata = 16'h9999;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (req_ready) rdy++;
            if (!mem_cs1_n || mem_cs2) sel++;
        end
        req_valid = 1'b0;
        chk("R12", "ready under standby", rdy, 0);
        chk("R12", "chip selected under standby", sel, 0);
        @(negedge clk);
        standby_req = 1'b0;
        do_read(16'h0077, 0, 0, int'(init_val(16'h77)), "R12");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_styles();
        t_read_timing();
        t_turnaround();
        t_standby();
        chk("R10", "model bus/data errors", model_errs, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule